// File: doc/BRIEF.md
# Ethernet Receive Frame Error Checker

This block takes a 4-bit receive stream from a media-independent PHY interface and looks for the start-of-frame marker. Once the marker is found, it packs the following nibbles into bytes, low nibble first, and sends each byte to the write port of a receive FIFO. While the frame is arriving, the block keeps a running IEEE 802.3 CRC-32 and a byte count. It also watches three inputs: the FIFO full flag, the FIFO parity-fault flag and the PHY receive-error line.

When receive-data-valid falls, the block reports the frame for one clock cycle. It raises a done strobe and drives a six-bit status word. The error bits in that word combine in fixed ways:

- A byte-alignment fault is only reported together with a CRC fault.
- A PHY receive error always forces a CRC fault, and it also drops the rest of the frame.
- A FIFO parity fault, when interrupts are enabled, aborts the frame.
- The length limit applies only while long-frame mode is off.

Top module: `rx_frame_checker`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `fifo_we_o` and `stat_o` are all zero until a frame ends.
- R2: The frame starts after a nibble 0x5 is followed by a nibble 0xD while `rx_dv_i` is high. Before that, no byte is written. If `rx_dv_i` drops without this pair having been seen, no done strobe is produced.
- R3: After the start marker, every pair of nibbles (low nibble first) forms one byte. Each byte, including the four FCS bytes, is presented on `fifo_data_o` with `fifo_we_o` high for one cycle, one cycle after its second nibble. A single trailing nibble is never written.
- R4: The first clock edge that samples `rx_dv_i` low after the start marker causes `done_o` to be high for exactly one cycle, with the status on `stat_o`. Outside that cycle, `stat_o` is zero. The status bit positions are: bit0 CRC error, bit1 alignment error, bit2 too-long, bit3 overflow, bit4 parity, bit5 PHY error.
- R5: The CRC-32 (reflected polynomial 0xEDB88320, initial value all ones) is computed over every nibble after the marker. The frame is good when the register ends at 0xDEBB20E3, which is 0xC704DD7B in bit-reversed form. Otherwise bit0 is set.
- R6: If the nibble count after the marker is odd and the CRC is bad, bits 1 and 0 are both set. An odd count never sets bit1 alone.
- R7: The byte count covers every byte from the one after the marker through the FCS. With `long_en_i` low, a count above MAX_LEN (1518) sets bit2, and a count of exactly 1518 does not. With `long_en_i` high, bit2 is never set.
- R8: A byte that completes while `fifo_full_i` is high is not written, and bit3 is set. The CRC is still computed over that byte.
- R9: If `fifo_par_err_i` and `irq_en_i` are both high during a data nibble, that nibble and all later nibbles of the frame are discarded. The status then has bit4 set, bits 0 to 2 cleared, and bit3 kept. If `irq_en_i` is low, `fifo_par_err_i` has no effect.
- R10: If `rx_er_i` is high during a data nibble, that nibble and all later nibbles are discarded. The status then has bits 5 and 0 set and bits 1, 2 and 4 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_dv_i | input | 1 | Receive data valid |
| rx_d_i | input | 4 | Receive nibble |
| rx_er_i | input | 1 | PHY receive error |
| long_en_i | input | 1 | Long-frame mode; turns off the length limit |
| irq_en_i | input | 1 | Interrupt enable; lets a parity fault abort the frame |
| fifo_full_i | input | 1 | Receive FIFO full |
| fifo_par_err_i | input | 1 | Receive FIFO parity fault |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write byte |
| done_o | output | 1 | End-of-frame strobe |
| stat_o | output | 6 | Frame status, valid while done_o is high |

## Verification
Each byte write is due one cycle after the edge that samples its high nibble. The bench drives inputs on the falling edge and checks writes with a monitor, also on the falling edge. The monitor compares every write, in order, with the bytes the bench itself built the frame from. The status and `done_o` are due one cycle after the first edge that samples `rx_dv_i` low. The bench therefore checks them at the first falling edge after dropping `rx_dv_i`, then checks one falling edge later that `done_o` has gone low again. For aborted frames, the expected write count is half the nibble index at which the fault was applied.

// File: rtl/rx_chk_pkg.sv
package rx_chk_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_DATA, ST_DROP} rx_state_e;

  // bit0 crc .. bit5 phy
  typedef struct packed {
    logic phy;
    logic par;
    logic ovf;
    logic too_long;
    logic align;
    logic crc;
  } rx_stat_t;

  localparam logic [3:0]  PRE_NIB  = 4'h5;
  localparam logic [3:0]  SFD_NIB  = 4'hD;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD = 32'hDEBB20E3;
endpackage

// File: rtl/rx_crc32_nib.sv
module rx_crc32_nib import rx_chk_pkg::*; #(
  parameter int NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [NW-1:0] nib_i,
  output logic          ok_o
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    for (int b = 0; b < NW; b++) begin
      crc_d = (crc_d[0] ^ nib_i[b]) ? ((crc_d >> 1) ^ CRC_POLY) : (crc_d >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '1;
    else if (clr_i) crc_q <= '1;
    else if (en_i)  crc_q <= crc_d;
  end

  assign ok_o = (crc_q == CRC_GOOD);

  // R5
  crc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ok_o);
endmodule

// File: rtl/rx_len_cnt.sv
module rx_len_cnt #(
  parameter int MAX_LEN = 1518,
  localparam int CW = $clog2(MAX_LEN + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic over_o
);
  localparam logic [CW-1:0] LIM = CW'(MAX_LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign over_o = (cnt_q == LIM);

  // R7
  over_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o && !clr_i |=> over_o);
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker import rx_chk_pkg::*; #(
  parameter int MAX_LEN = 1518,
  parameter int NW      = 4,
  localparam int BW     = 2 * NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_dv_i,
  input  logic [NW-1:0] rx_d_i,
  input  logic          rx_er_i,
  input  logic          long_en_i,
  input  logic          irq_en_i,
  input  logic          fifo_full_i,
  input  logic          fifo_par_err_i,
  output logic          fifo_we_o,
  output logic [BW-1:0] fifo_data_o,
  output logic          done_o,
  output logic [5:0]    stat_o
);
  rx_state_e     state_q;
  logic [NW-1:0] prev_q, lo_q;
  logic          odd_q, ovf_q, par_q, phy_q;
  logic          we_q, done_q;
  logic [BW-1:0] data_q;
  rx_stat_t      stat_q, stat_d;

  logic in_data, abort_phy, abort_par, nib_ok, byte_done, eof, sfd_hit, hunt;
  logic crc_ok, len_over;

  assign hunt      = (state_q == ST_HUNT);
  assign in_data   = (state_q == ST_DATA) && rx_dv_i;
  assign abort_phy = in_data && rx_er_i;
  assign abort_par = in_data && !rx_er_i && fifo_par_err_i && irq_en_i;
  assign nib_ok    = in_data && !abort_phy && !abort_par;
  assign byte_done = nib_ok && odd_q;
  assign eof       = !hunt && !rx_dv_i;
  assign sfd_hit   = hunt && rx_dv_i && prev_q == PRE_NIB[NW-1:0] && rx_d_i == SFD_NIB[NW-1:0];

  rx_crc32_nib #(.NW(NW)) i_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (hunt),
    .en_i  (nib_ok),
    .nib_i (rx_d_i),
    .ok_o  (crc_ok)
  );

  rx_len_cnt #(.MAX_LEN(MAX_LEN)) i_len (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (hunt),
    .inc_i (byte_done),
    .over_o(len_over)
  );

  always_comb begin
    stat_d     = '0;
    stat_d.ovf = ovf_q;
    if (par_q) begin
      stat_d.par = 1'b1;
    end else if (phy_q) begin
      stat_d.phy = 1'b1;
      stat_d.crc = 1'b1;
    end else begin
      stat_d.crc      = !crc_ok;
      stat_d.align    = odd_q && !crc_ok;
      stat_d.too_long = len_over && !long_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      prev_q  <= '0;
      lo_q    <= '0;
      odd_q   <= 1'b0;
      ovf_q   <= 1'b0;
      par_q   <= 1'b0;
      phy_q   <= 1'b0;
      we_q    <= 1'b0;
      data_q  <= '0;
      done_q  <= 1'b0;
      stat_q  <= '0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      stat_q <= '0;
      if (hunt) begin
        prev_q <= rx_dv_i ? rx_d_i : '0;
        if (sfd_hit) begin
          state_q <= ST_DATA;
          odd_q   <= 1'b0;
          ovf_q   <= 1'b0;
          par_q   <= 1'b0;
          phy_q   <= 1'b0;
        end
      end else if (eof) begin
        state_q <= ST_HUNT;
        prev_q  <= '0;
        done_q  <= 1'b1;
        stat_q  <= stat_d;
      end else if (abort_phy) begin
        phy_q   <= 1'b1;
        state_q <= ST_DROP;
      end else if (abort_par) begin
        par_q   <= 1'b1;
        state_q <= ST_DROP;
      end else if (nib_ok) begin
        odd_q <= !odd_q;
        if (!odd_q) begin
          lo_q <= rx_d_i;
        end else if (fifo_full_i) begin
          ovf_q <= 1'b1;
        end else begin
          we_q   <= 1'b1;
          data_q <= {rx_d_i, lo_q};
        end
      end
    end
  end

  assign fifo_we_o   = we_q;
  assign fifo_data_o = data_q;
  assign done_o      = done_q;
  assign stat_o      = stat_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  done_after_dv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$past(rx_dv_i));
  // R4
  stat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> stat_o == '0);
  // R6
  align_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[1] |-> stat_o[0]);
  // R10
  phy_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[5] |-> stat_o[0] && !stat_o[4]);
  // R8
  no_full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> !$past(fifo_full_i));
  // R2
  no_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt && !$past(hunt) |-> !done_o || !fifo_we_o);
endmodule

// File: tb/test_rx_frame_checker.sv
module test_rx_frame_checker;
  localparam int CLK_PER = 10;

  typedef struct packed {
    logic [10:0] len;
    logic        odd;
    logic        long_en;
    logic        full;
    logic        irq;
    logic [11:0] par_at;
    logic [11:0] er_at;
    logic [5:0]  exp;
  } vec_t;

  localparam logic [11:0] NONE = 12'hFFF;
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{11'd46,   1'b0, 1'b0, 1'b0, 1'b1, NONE,   NONE,   6'h00}, // R3 R5 good
    '{11'd60,   1'b1, 1'b0, 1'b0, 1'b1, NONE,   NONE,   6'h03}, // R6
    '{11'd1514, 1'b0, 1'b0, 1'b0, 1'b1, NONE,   NONE,   6'h00}, // R7 exactly 1518
    '{11'd1515, 1'b0, 1'b0, 1'b0, 1'b1, NONE,   NONE,   6'h04}, // R7 1519
    '{11'd1515, 1'b0, 1'b1, 1'b0, 1'b1, NONE,   NONE,   6'h00}, // R7 long mode
    '{11'd1515, 1'b1, 1'b0, 1'b0, 1'b1, NONE,   NONE,   6'h07}, // R6 R7
    '{11'd50,   1'b0, 1'b0, 1'b1, 1'b1, NONE,   NONE,   6'h08}, // R8
    '{11'd50,   1'b0, 1'b0, 1'b0, 1'b1, 12'd20, NONE,   6'h10}, // R9
    '{11'd50,   1'b0, 1'b0, 1'b0, 1'b0, 12'd20, NONE,   6'h00}, // R9 ignored
    '{11'd50,   1'b0, 1'b0, 1'b0, 1'b1, NONE,   12'd30, 6'h21}, // R10
    '{11'd100,  1'b0, 1'b0, 1'b0, 1'b1, NONE,   NONE,   6'h00}  // R3
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_dv_i = 1'b0;
  logic [3:0] rx_d_i = '0;
  logic       rx_er_i = 1'b0;
  logic       long_en_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       fifo_full_i = 1'b0;
  logic       fifo_par_err_i = 1'b0;
  logic       fifo_we_o;
  logic [7:0] fifo_data_o;
  logic       done_o;
  logic [5:0] stat_o;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  int mism = 0;
  int done_cnt = 0;
  int cyc = 0;
  logic [7:0] fr [0:1600];

  rx_frame_checker i_rx_frame_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_dv_i(rx_dv_i), .rx_d_i(rx_d_i),
    .rx_er_i(rx_er_i), .long_en_i(long_en_i), .irq_en_i(irq_en_i),
    .fifo_full_i(fifo_full_i), .fifo_par_err_i(fifo_par_err_i),
    .fifo_we_o(fifo_we_o), .fifo_data_o(fifo_data_o), .done_o(done_o), .stat_o(stat_o)
  );

  always #(CLK_PER/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (fifo_we_o) begin
      if (wr_cnt > 1600 || fifo_data_o !== fr[wr_cnt]) mism = mism + 1;
      wr_cnt = wr_cnt + 1;
    end
    if (done_o) done_cnt = done_cnt + 1;
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic send_nib(input logic [3:0] d, input logic er, input logic par);
    @(negedge clk_i);
    rx_dv_i = 1'b1; rx_d_i = d; rx_er_i = er; fifo_par_err_i = par;
  endtask

  task automatic run_frame(input vec_t v, input int idx);
    int n;
    int nn;
    int exp_wr;
    logic [31:0] c;
    logic [3:0] nib;
    n = int'(v.len);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      fr[i] = 8'((i * 13 + idx * 7) & 255);
      c = crc_byte(c, fr[i]);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) fr[n + i] = c[8*i +: 8];
    n = n + 4;
    if (v.full) exp_wr = 0;
    else if (v.par_at != NONE && v.irq) exp_wr = int'(v.par_at) / 2;
    else if (v.er_at != NONE) exp_wr = int'(v.er_at) / 2;
    else exp_wr = n;
    wr_cnt = 0; mism = 0;
    long_en_i = v.long_en; irq_en_i = v.irq; fifo_full_i = v.full;
    for (int i = 0; i < 15; i++) send_nib(4'h5, 1'b0, 1'b0);
    send_nib(4'hD, 1'b0, 1'b0);
    nn = 2 * n + (v.odd ? 1 : 0);
    for (int k = 0; k < nn; k++) begin
      if (k >= 2 * n) nib = 4'hA;
      else nib = (k % 2 == 1) ? fr[k/2][7:4] : fr[k/2][3:0];
      send_nib(nib, 12'(k) == v.er_at, 12'(k) == v.par_at);
    end
    @(negedge clk_i);
    rx_dv_i = 1'b0; rx_er_i = 1'b0; fifo_par_err_i = 1'b0; rx_d_i = '0;
    @(negedge clk_i);
    check($sformatf("R4 done vec%0d", idx), int'(done_o), 1);
    check($sformatf("R5-status vec%0d R6 R7 R8 R9 R10", idx), int'(stat_o), int'(v.exp));
    @(negedge clk_i);
    check($sformatf("R4 one-cycle vec%0d", idx), int'(done_o), 0);
    check($sformatf("R3 write count vec%0d", idx), wr_cnt, exp_wr);
    check($sformatf("R3 write data vec%0d", idx), mism, 0);
    fifo_full_i = 1'b0;
  endtask

  initial begin
    #(CLK_PER * 2);
    check("R1 done in reset", int'(done_o), 0);
    check("R1 stat in reset", int'(stat_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 we after reset", int'(fifo_we_o), 0);
    check("R1 done after reset", int'(done_o), 0);

    // R2: preamble only, no marker
    done_cnt = 0; wr_cnt = 0;
    for (int i = 0; i < 12; i++) send_nib(4'h5, 1'b0, 1'b0);
    send_nib(4'h7, 1'b0, 1'b0);
    send_nib(4'hD, 1'b0, 1'b0);
    @(negedge clk_i); rx_dv_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R2 no done without marker", done_cnt, 0);
    check("R2 no write without marker", wr_cnt, 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VECS[v], v);
      repeat (2) @(negedge clk_i);
    end

    // R4: status zero after pulse
    check("R4 stat idle", int'(stat_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule